// File: doc/BRIEF.md
# Two-Entry Receive Queue with Overflow Reporting

This block holds characters delivered by a serial receiver until software reads them. The shift engine pushes one character per push strobe. The read port always shows the oldest held character, and a pop strobe removes it. A receive-complete output stays high while anything is waiting to be read. The queue holds two characters.

A character that arrives while both slots are full is lost, and a sticky overflow status bit reports the loss. The bit is reported in one of two ways, chosen by a mode input:

- **Immediate mode:** the bit rises at once. Software then drains the queue by reading until receive-complete drops.
- **In-line mode:** a zero-valued marker joins the queue behind the characters already stored. The bit rises only when everything ahead of the marker has been read. The next read returns zero and removes the marker.

Software clears the bit by writing a one. Dropping the receiver enable clears the bit and empties the queue.

Top module: `rxq_fifo`

## Requirements
- R1: After reset, `rx_done` is 0, `ovf_flag` is 0 and `rd_data` is 0.
- R2: Characters are read back in push order. `rd_data` shows the oldest held character, and each `pop_req` removes it at the clock edge. Up to DEPTH = 2 characters are held.
- R3: `rx_done` is 1 exactly when at least one character or an in-line overflow marker is held.
- R4: A push that arrives with both slots full, and with no character popped in the same cycle, is dropped. The stored characters stay unchanged.
- R5: With `imm_mode` = 1, `ovf_flag` is 1 from the clock edge that drops the character.
- R6: With `imm_mode` = 0, an overflow queues a marker behind the stored characters, and `ovf_flag` stays 0 meanwhile. `ovf_flag` rises at the edge where the last character ahead of the marker is popped, while `rx_done` stays 1. The next read shows `rd_data` = 0, and popping it removes the marker.
- R7: `ovf_flag` holds until a cycle with `ovf_clr` = 1 clears it. A new overflow event in that same cycle wins, and the bit stays 1.
- R8: While `rx_en` = 0, the block empties the queue, drops any marker and clears `ovf_flag` at the next edge. Pushes, pops and clears are ignored while `rx_en` = 0.
- R9: With nothing held, `rd_data` reads 0, and a pop changes nothing.
- R10: A push and a pop in the same cycle on a full queue is not an overflow. The oldest character leaves and the new one is stored.
- R11: Characters pushed after an in-line marker are read after the marker's zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes the queue and clears the flag |
| imm_mode | input | 1 | 1 = immediate overflow reporting, 0 = in-line |
| push_valid | input | 1 | Push strobe from the shift engine |
| push_data | input | DATA_W | Character being pushed |
| pop_req | input | 1 | Read strobe; removes the head item |
| rd_data | output | DATA_W | Oldest character, or 0 when empty or when the marker is at the head |
| rx_done | output | 1 | Receive complete: data or marker held |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow bit |
| ovf_flag | output | 1 | Sticky overflow status |

## Verification
- `rd_data` is combinational from the stored state. It is due in the same cycle as the pop that consumes it, so the bench compares it before that clock edge.
- `rx_done` and `ovf_flag` are single registers, or are derived from registers. They are due one edge after the push, pop, clear or disable that changes them.
- The in-line flag is due on the edge that pops the last character ahead of the marker.
- The bench drives every input 2 ns after a rising edge and samples all outputs at the same point. A scoreboard queue holds the characters and markers expected in order.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic {
    OVF_INLINE    = 1'b0,
    OVF_IMMEDIATE = 1'b1
  } ovf_mode_e;

  // Next value of a circular pointer over `depth` slots.
  function automatic int wrap_inc(input int ptr, input int depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

  // Occupancy after one cycle with optional insert and remove.
  function automatic int level_next(input int lvl, input logic ins, input logic rem);
    return lvl + int'(ins) - int'(rem);
  endfunction

  // Items ahead of the marker after one data pop.
  function automatic int ahead_next(input int ahead, input logic dpop);
    return (dpop && ahead != 0) ? ahead - 1 : ahead;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] head_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic              full,
  output logic              empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;

  assign full      = (level == LW'(DEPTH));
  assign empty     = (level == '0);
  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= PW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (rd_en) rd_ptr <= PW'(wrap_inc(int'(rd_ptr), DEPTH));
      level <= LW'(level_next(int'(level), wr_en, rd_en));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && !flush) begin
      mem[wr_ptr] <= wr_data;
    end
  end

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R4
  store_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!full || rd_en));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);

endmodule

// File: rtl/rxq_marker.sv
module rxq_marker
  import rxq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic inline_mode,
  input  logic ovf_evt,
  input  logic data_pop,
  input  logic mark_take,
  output logic mark_pend,
  output logic mark_head,
  output logic mark_arrive
);
  localparam int AW = $clog2(DEPTH+1);

  logic [AW-1:0] ahead;
  logic          mark_new;

  assign mark_head   = mark_pend && (ahead == '0);
  assign mark_arrive = mark_pend && data_pop && (ahead == AW'(1));
  assign mark_new    = ovf_evt && inline_mode && (!mark_pend || mark_take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_pend <= 1'b0;
      ahead     <= '0;
    end else if (flush) begin
      mark_pend <= 1'b0;
      ahead     <= '0;
    end else if (mark_new) begin
      mark_pend <= 1'b1;
      ahead     <= AW'(DEPTH);
    end else if (mark_take) begin
      mark_pend <= 1'b0;
      ahead     <= '0;
    end else if (mark_pend) begin
      ahead <= AW'(ahead_next(int'(ahead), data_pop));
    end
  end

  // R6
  marker_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_arrive && !flush) |=> mark_head);

  // R6
  marker_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && inline_mode && !flush) |=> mark_pend);

  // R6
  marker_behind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_new && !flush) |=> !mark_head);

endmodule

// File: rtl/rxq_ovf.sv
module rxq_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (!rx_en) flag <= 1'b0;
    else             flag <= set_evt || (flag && !clr_req);
  end

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && rx_en && !clr_req) |=> flag);

  // R7
  ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && rx_en) |=> flag);

  // R8
  ovf_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !flag);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              imm_mode,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_done,
  input  logic              ovf_clr,
  output logic              ovf_flag
);
  localparam int LW = $clog2(DEPTH+1);

  ovf_mode_e         mode;
  logic              flush;
  logic              full, empty;
  logic [LW-1:0]     level;
  logic [DATA_W-1:0] head_data;
  logic              mark_pend, mark_head, mark_arrive;
  logic              data_pop, mark_take, push_ok, ovf_evt, set_evt;

  assign mode      = ovf_mode_e'(imm_mode);
  assign flush     = !rx_en;
  assign data_pop  = rx_en && pop_req && !mark_head && !empty;
  assign mark_take = rx_en && pop_req && mark_head;
  assign push_ok   = rx_en && push_valid && (!full || data_pop);
  assign ovf_evt   = rx_en && push_valid && full && !data_pop;
  assign set_evt   = (ovf_evt && mode == OVF_IMMEDIATE) || mark_arrive;

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wr_en     (push_ok),
    .wr_data   (push_data),
    .rd_en     (data_pop),
    .head_data (head_data),
    .level     (level),
    .full      (full),
    .empty     (empty)
  );

  rxq_marker #(.DEPTH(DEPTH)) u_marker (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .inline_mode (mode == OVF_INLINE),
    .ovf_evt     (ovf_evt),
    .data_pop    (data_pop),
    .mark_take   (mark_take),
    .mark_pend   (mark_pend),
    .mark_head   (mark_head),
    .mark_arrive (mark_arrive)
  );

  rxq_ovf u_ovf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .set_evt (set_evt),
    .clr_req (ovf_clr),
    .flag    (ovf_flag)
  );

  assign rd_data = (!empty && !mark_head) ? head_data : '0;
  assign rx_done = !empty || mark_pend;

  // R9
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> (rd_data == '0));

  // R3
  push_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> rx_done);

  // R4
  drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (level == LW'(DEPTH)));

  // R5
  imm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && imm_mode) |=> ovf_flag);

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_done);

endmodule

// File: tb/test_rxq_fifo.sv
module test_rxq_fifo;
  localparam int W = 8;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b1;
  logic imm_mode = 1'b1;
  logic push_valid = 1'b0;
  logic [W-1:0] push_data = '0;
  logic pop_req = 1'b0;
  logic ovf_clr = 1'b0;
  logic [W-1:0] rd_data;
  logic rx_done, ovf_flag;

  int checks = 0;
  int errors = 0;
  int exp_q[$];      // -1 stands for the in-line overflow marker
  bit exp_flag = 0;

  always #4 clk = ~clk;

  rxq_fifo #(.DATA_W(W), .DEPTH(DEPTH)) i_rxq_fifo (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .imm_mode(imm_mode),
    .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
    .rd_data(rd_data), .rx_done(rx_done), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int data_cnt();
    int n = 0;
    foreach (exp_q[i]) if (exp_q[i] != -1) n++;
    return n;
  endfunction

  function automatic bit has_mark();
    foreach (exp_q[i]) if (exp_q[i] == -1) return 1;
    return 0;
  endfunction

  // Driver: one cycle of stimulus, scoreboard update, then monitor checks.
  task automatic cyc(input bit p, input int d, input bit rd, input bit clr, input string tag);
    if (rd) check({tag, " read"}, int'(rd_data),
                  (exp_q.size() != 0 && exp_q[0] != -1) ? exp_q[0] : 0);
    push_valid = p; push_data = W'(d); pop_req = rd; ovf_clr = clr;
    @(posedge clk); #2;
    push_valid = 0; pop_req = 0; ovf_clr = 0;
    if (!rx_en) begin
      exp_q.delete();
      exp_flag = 0;
    end else begin
      if (clr) exp_flag = 0;
      if (rd && exp_q.size() != 0) begin
        if (exp_q[0] == -1) void'(exp_q.pop_front());
        else begin
          void'(exp_q.pop_front());
          if (exp_q.size() != 0 && exp_q[0] == -1) exp_flag = 1;
        end
      end
      if (p) begin
        if (data_cnt() < DEPTH) exp_q.push_back(d);
        else if (imm_mode) exp_flag = 1;
        else if (!has_mark()) exp_q.push_back(-1);
      end
    end
    check({tag, " rx_done"}, int'(rx_done), int'(exp_q.size() != 0));
    check({tag, " ovf_flag"}, int'(ovf_flag), int'(exp_flag));
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #10; rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    check("R1 rx_done", int'(rx_done), 0);
    check("R1 ovf_flag", int'(ovf_flag), 0);
    check("R1 rd_data", int'(rd_data), 0);

    // R2 / R3 ordering, immediate mode
    imm_mode = 1;
    cyc(1, 8'h11, 0, 0, "R3");
    cyc(1, 8'h22, 0, 0, "R2");
    cyc(0, 0, 1, 0, "R2");
    cyc(1, 8'h33, 0, 0, "R2");
    cyc(0, 0, 1, 0, "R2");
    cyc(0, 0, 1, 0, "R3");
    // R9 read of an empty queue
    cyc(0, 0, 1, 0, "R9");
    check("R9 rd_data idle", int'(rd_data), 0);

    // R4 / R5 immediate overflow
    cyc(1, 8'hA1, 0, 0, "R4");
    cyc(1, 8'hA2, 0, 0, "R4");
    cyc(1, 8'hA3, 0, 0, "R5");
    cyc(0, 0, 1, 0, "R4");
    cyc(0, 0, 1, 0, "R4");
    cyc(0, 0, 1, 0, "R4");
    // R7 sticky then cleared
    cyc(0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 1, "R7");
    // R7 set wins over clear
    cyc(1, 8'hB1, 0, 0, "R7");
    cyc(1, 8'hB2, 0, 0, "R7");
    cyc(1, 8'hB3, 0, 1, "R7");
    cyc(0, 0, 0, 1, "R7");
    // R10 push and pop on a full queue
    cyc(1, 8'hC3, 1, 0, "R10");
    cyc(0, 0, 1, 0, "R10");
    cyc(0, 0, 1, 0, "R10");
    cyc(0, 0, 0, 0, "R10");

    // R6 in-line overflow
    imm_mode = 0;
    cyc(1, 8'hD1, 0, 0, "R6");
    cyc(1, 8'hD2, 0, 0, "R6");
    cyc(1, 8'hD3, 0, 0, "R6");
    cyc(0, 0, 1, 0, "R6");
    cyc(0, 0, 1, 0, "R6");
    cyc(0, 0, 1, 0, "R6");
    cyc(0, 0, 0, 1, "R6");
    // R11 characters behind the marker
    cyc(1, 8'hE1, 0, 0, "R11");
    cyc(1, 8'hE2, 0, 0, "R11");
    cyc(1, 8'hE3, 0, 0, "R11");
    cyc(0, 0, 1, 0, "R11");
    cyc(1, 8'hE4, 0, 0, "R11");
    cyc(0, 0, 1, 0, "R11");
    cyc(0, 0, 1, 0, "R11");
    cyc(0, 0, 1, 0, "R11");
    cyc(0, 0, 0, 1, "R11");

    // R8 disable flushes and ignores
    imm_mode = 1;
    cyc(1, 8'hF1, 0, 0, "R8");
    cyc(1, 8'hF2, 0, 0, "R8");
    cyc(1, 8'hF3, 0, 0, "R8");
    rx_en = 0;
    cyc(0, 0, 0, 0, "R8");
    cyc(1, 8'hF4, 0, 0, "R8");
    rx_en = 1;
    cyc(0, 0, 0, 0, "R8");
    cyc(0, 0, 1, 0, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule